// File: doc/BRIEF.md
# Two-Table Byte Permute Unit

This unit rearranges the bytes of a vector operand according to per-byte indices. The vector is 16, 32 or 64 bytes long. In the single-table operation, each index byte addresses one table. In the two two-table operations, each index byte carries one extra bit just above its position field. That bit decides which of two tables the byte is read from. The two-table operations differ in which operand supplies the indices and which operands act as the tables.

The result is merged under an optional per-byte write mask. Bytes that are not written either keep the old destination byte or are zeroed, depending on a flag. Bytes above the active vector length always come out as zero. A request is accepted with a valid strobe. The registered result appears one clock later, together with a valid flag. Instruction decode and register-file access belong to the surrounding datapath.

Top module: `vperm_byte_unit`

## Requirements
- R1: The vector-length code `vlen_i` sets the element count E: 0 gives 16 bytes, 1 gives 32 bytes, and 2 or 3 give 64 bytes. An index byte addresses table byte (index AND (E-1)).
- R2: With `op_i` 0 (single table), or 3 (treated the same way), result byte n is src2 byte (src1[n] AND (E-1)). Index bits at or above log2(E) are ignored.
- R3: With `op_i` 1, indices come from src1. If index bit log2(E) (value E) is set, the byte is src2[pos]; if it is clear, the byte is the old dst[pos].
- R4: With `op_i` 2, indices come from the old dst. If index bit log2(E) is set, the byte is src2[pos]; if it is clear, the byte is src1[pos].
- R5: Every result byte is computed from the operand values presented with the request, never from a partly updated destination. This holds even when dst supplies both the indices and the merge data.
- R6: With `mask_en_i` low, all E bytes take the permuted value and bytes E and above are zero.
- R7: With `mask_en_i` high and `zero_i` low, byte n below E takes the permuted value when `mask_i[n]` is 1. Otherwise it keeps the old dst byte n.
- R8: With `mask_en_i` high and `zero_i` high, an unselected byte below E becomes zero. `zero_i` has no effect while `mask_en_i` is low.
- R9: In masked mode, bytes E and above are also zero, and mask bits at or above E have no effect.
- R10: After reset, `valid_o` is 0 and `data_o` is zero. A request with `valid_i` high produces `valid_o` high and the result on `data_o` one clock later. Without a request, `valid_o` is low and `data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | Operation: 0 single table, 1 two-table with src1 indices, 2 two-table with dst indices, 3 single table |
| vlen_i | input | 2 | Vector-length code (0: 16 B, 1: 32 B, 2/3: 64 B) |
| src1_i | input | 512 | First source vector, byte n at bits 8n+7:8n |
| src2_i | input | 512 | Second source vector |
| dst_i | input | 512 | Old destination vector |
| mask_en_i | input | 1 | Write-mask enable |
| mask_i | input | 64 | Per-byte write mask, bit n for byte n |
| zero_i | input | 1 | Zero unselected bytes instead of keeping them |
| valid_o | output | 1 | Result valid, one clock after the request |
| data_o | output | 512 | New destination vector |

## Verification
The bench builds the unit with its default parameters: a 16-byte minimum length and three length codes, giving 64-byte vectors. This brings every length code within reach, including the spare code 3, along with index bytes whose table bit and upper bits take every combination. Each of the four operation codes is crossed with each length code and with four mask and zero-flag settings, over random and edge-valued operands and masks. The bench then checks the hold behaviour between requests.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

  typedef enum logic [1:0] {
    OP_ONE_TBL = 2'd0,
    OP_TWO_IDX_SRC = 2'd1,
    OP_TWO_IDX_DST = 2'd2,
    OP_ONE_ALT = 2'd3
  } vperm_op_e;

endpackage

// File: rtl/vperm_len_dec.sv
module vperm_len_dec #(
  parameter int MIN_BYTES = 16,
  parameter int NUM_LEN = 3,
  localparam int MAX_BYTES = MIN_BYTES << (NUM_LEN - 1),
  localparam int PW = $clog2(MAX_BYTES),
  localparam int LW = $clog2(NUM_LEN + 1)
) (
  input  logic [LW-1:0]        vlen_i,
  output logic [PW:0]          tbl_bit_o,
  output logic [PW-1:0]        pos_mask_o,
  output logic [MAX_BYTES-1:0] active_o
);

  logic [LW-1:0] code_sat;
  logic [PW:0]   mask_full;

  always_comb begin
    code_sat = vlen_i;
    if (int'(vlen_i) >= NUM_LEN) code_sat = LW'(NUM_LEN - 1);
    tbl_bit_o  = (PW+1)'(MIN_BYTES) << code_sat;
    mask_full  = tbl_bit_o - (PW+1)'(1);
    pos_mask_o = mask_full[PW-1:0];
  end

  // byte n is active when it has no bits above the position field
  for (genvar n = 0; n < MAX_BYTES; n++) begin : g_act
    assign active_o[n] = ((PW'(n) & ~pos_mask_o) == '0);
  end

endmodule

// File: rtl/vperm_byte_sel.sv
module vperm_byte_sel #(
  parameter int MAX_BYTES = 64,
  localparam int PW = $clog2(MAX_BYTES)
) (
  input  logic [7:0]                  idx_i,
  input  logic [PW:0]                 tbl_bit_i,
  input  logic [PW-1:0]               pos_mask_i,
  input  logic                        two_tbl_i,
  input  logic [MAX_BYTES-1:0][7:0]   tbl0_i,
  input  logic [MAX_BYTES-1:0][7:0]   tbl1_i,
  output logic [7:0]                  byte_o
);

  logic [PW-1:0] pos;
  logic          pick_hi;

  always_comb begin
    pos     = idx_i[PW-1:0] & pos_mask_i;
    pick_hi = two_tbl_i & (|(idx_i[PW:0] & tbl_bit_i));
    byte_o  = pick_hi ? tbl1_i[pos] : tbl0_i[pos];
  end

endmodule

// File: rtl/vperm_merge.sv
module vperm_merge #(
  parameter int MAX_BYTES = 64
) (
  input  logic [MAX_BYTES-1:0][7:0] perm_i,
  input  logic [MAX_BYTES-1:0][7:0] old_i,
  input  logic [MAX_BYTES-1:0]      active_i,
  input  logic                      mask_en_i,
  input  logic [MAX_BYTES-1:0]      mask_i,
  input  logic                      zero_i,
  output logic [MAX_BYTES-1:0][7:0] res_o
);

  always_comb begin
    for (int n = 0; n < MAX_BYTES; n++) begin
      if (!active_i[n])                 res_o[n] = '0;
      else if (!mask_en_i || mask_i[n]) res_o[n] = perm_i[n];
      else if (zero_i)                  res_o[n] = '0;
      else                              res_o[n] = old_i[n];
    end
  end

endmodule

// File: rtl/vperm_byte_unit.sv
module vperm_byte_unit
  import vperm_pkg::*;
#(
  parameter int MIN_BYTES = 16,
  parameter int NUM_LEN = 3,
  localparam int MAX_BYTES = MIN_BYTES << (NUM_LEN - 1),
  localparam int PW = $clog2(MAX_BYTES),
  localparam int LW = $clog2(NUM_LEN + 1),
  localparam int VW = MAX_BYTES * 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [1:0]           op_i,
  input  logic [LW-1:0]        vlen_i,
  input  logic [VW-1:0]        src1_i,
  input  logic [VW-1:0]        src2_i,
  input  logic [VW-1:0]        dst_i,
  input  logic                 mask_en_i,
  input  logic [MAX_BYTES-1:0] mask_i,
  input  logic                 zero_i,
  output logic                 valid_o,
  output logic [VW-1:0]        data_o
);

  logic [MAX_BYTES-1:0][7:0] s1_b, s2_b, d_b, idx_b, tbl0_b, perm_b, res_b;
  logic [PW:0]               tbl_bit;
  logic [PW-1:0]             pos_mask;
  logic [MAX_BYTES-1:0]      active;
  logic                      two_tbl;
  vperm_op_e                 op;

  assign s1_b = src1_i;
  assign s2_b = src2_i;
  assign d_b  = dst_i;
  assign op   = vperm_op_e'(op_i);

  // operand routing: src2 is always the upper table
  always_comb begin
    two_tbl = 1'b0;
    idx_b   = s1_b;
    tbl0_b  = s2_b;
    unique case (op)
      OP_TWO_IDX_SRC: begin two_tbl = 1'b1; idx_b = s1_b; tbl0_b = d_b;  end
      OP_TWO_IDX_DST: begin two_tbl = 1'b1; idx_b = d_b;  tbl0_b = s1_b; end
      default:        begin two_tbl = 1'b0; idx_b = s1_b; tbl0_b = s2_b; end
    endcase
  end

  vperm_len_dec #(.MIN_BYTES(MIN_BYTES), .NUM_LEN(NUM_LEN)) u_len (
    .vlen_i    (vlen_i),
    .tbl_bit_o (tbl_bit),
    .pos_mask_o(pos_mask),
    .active_o  (active)
  );

  for (genvar n = 0; n < MAX_BYTES; n++) begin : g_sel
    vperm_byte_sel #(.MAX_BYTES(MAX_BYTES)) u_sel (
      .idx_i     (idx_b[n]),
      .tbl_bit_i (tbl_bit),
      .pos_mask_i(pos_mask),
      .two_tbl_i (two_tbl),
      .tbl0_i    (tbl0_b),
      .tbl1_i    (s2_b),
      .byte_o    (perm_b[n])
    );
  end

  vperm_merge #(.MAX_BYTES(MAX_BYTES)) u_merge (
    .perm_i   (perm_b),
    .old_i    (d_b),
    .active_i (active),
    .mask_en_i(mask_en_i),
    .mask_i   (mask_i),
    .zero_i   (zero_i),
    .res_o    (res_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= res_b;
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R10
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(data_o)));

  // R6
  upper_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && vlen_i == '0) |=> (data_o[VW-1:MIN_BYTES*8] == '0));

  // R8
  zero_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_en_i && zero_i && mask_i == '0) |=> (data_o == '0));

  // R7
  keep_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_en_i && !zero_i && mask_i == '0 && int'(vlen_i) >= NUM_LEN - 1)
    |=> (data_o == $past(dst_i)));

endmodule

// File: tb/vperm_byte_unit_tb.sv
`timescale 1ns/1ps
module vperm_byte_unit_tb;

  localparam int NB = 64;
  localparam int VW = NB * 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [1:0]    op_i = '0;
  logic [1:0]    vlen_i = '0;
  logic [VW-1:0] src1_i = '0, src2_i = '0, dst_i = '0;
  logic          mask_en_i = 1'b0;
  logic [NB-1:0] mask_i = '0;
  logic          zero_i = 1'b0;
  logic          valid_o;
  logic [VW-1:0] data_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vperm_byte_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .vlen_i(vlen_i),
    .src1_i(src1_i), .src2_i(src2_i), .dst_i(dst_i), .mask_en_i(mask_en_i),
    .mask_i(mask_i), .zero_i(zero_i), .valid_o(valid_o), .data_o(data_o)
  );

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int k = 0; k < VW / 32; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  // independent model of R1..R9
  function automatic logic [VW-1:0] model(int op, int vl, logic [VW-1:0] s1,
      logic [VW-1:0] s2, logic [VW-1:0] d, bit men, logic [NB-1:0] m, bit z);
    logic [VW-1:0] r;
    int e, idx, pos;
    bit hi;
    logic [7:0] b;
    e = 16 << ((vl > 2) ? 2 : vl);
    for (int n = 0; n < NB; n++) begin
      if (n >= e) begin
        b = 8'h00;
      end else begin
        idx = (op == 2) ? int'(d[8*n +: 8]) : int'(s1[8*n +: 8]);
        pos = idx % e;
        hi  = ((idx / e) % 2) == 1;
        if (op == 1)      b = hi ? s2[8*pos +: 8] : d[8*pos +: 8];
        else if (op == 2) b = hi ? s2[8*pos +: 8] : s1[8*pos +: 8];
        else              b = s2[8*pos +: 8];
        if (men && !m[n]) b = z ? 8'h00 : d[8*n +: 8];
      end
      r[8*n +: 8] = b;
    end
    return r;
  endfunction

  task automatic check(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(int op, int vl, int pat, int mode);
    logic [VW-1:0] exp;
    string tag;
    @(negedge clk);
    op_i = 2'(op);
    vlen_i = 2'(vl);
    src1_i = rand_vec();
    src2_i = rand_vec();
    dst_i = rand_vec();
    if (pat == 1) src1_i = '1;
    if (pat == 2) dst_i = '0;
    mask_en_i = (mode >= 2);
    zero_i = (mode % 2) == 1;
    mask_i = {$urandom, $urandom};
    if (pat == 3) mask_i = '0;
    if (pat == 4) mask_i = '1;
    valid_i = 1'b1;
    exp = model(op, vl, src1_i, src2_i, dst_i, mask_en_i, mask_i, zero_i);
    @(negedge clk);
    valid_i = 1'b0;
    tag = $sformatf("R1 R5 %s %s op=%0d vl=%0d pat=%0d",
      (op == 1) ? "R3" : (op == 2) ? "R4" : "R2",
      (mode == 0) ? "R6" : (mode == 1) ? "R6 R8" : (mode == 2) ? "R7 R9" : "R8 R9",
      op, vl, pat);
    check(tag, data_o, exp);
    check("R10 valid_o after request", {511'b0, valid_o}, {511'b0, 1'b1});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] held;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset data_o", data_o, '0);
    check("R10 reset valid_o", {511'b0, valid_o}, '0);
    rst_ni = 1'b1;
    for (int op = 0; op < 4; op++)
      for (int vl = 0; vl < 4; vl++)
        for (int pat = 0; pat < 8; pat++)
          for (int mode = 0; mode < 4; mode++)
            run_op(op, vl, pat, mode);
    // R10 hold without request while inputs move
    held = data_o;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      src1_i = rand_vec();
      src2_i = rand_vec();
      dst_i = rand_vec();
      op_i = 2'(k);
      @(negedge clk);
      check("R10 hold data_o", data_o, held);
      check("R10 idle valid_o", {511'b0, valid_o}, '0);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule